// File: doc/BRIEF.md
# Synchronous Serial Converter-Link Master

This block drives the master end of a full-duplex, four-wire serial link to an external converter. From the system clock it builds a serial clock whose period is a programmable whole number of system cycles. It frames each transfer with an active-low select line. While a 26-bit command word leaves on the data output, a 26-bit result word arrives on the data input. Both words travel most significant bit first. Every serial output is a register in the system clock domain, so no derived clock exists inside the chip.

A word to send is handed over on a valid/ready port. `tx_ready` is high whenever no transfer is running. A word is taken on any cycle where `tx_valid` and `tx_ready` are both high, and the divider setting is captured in that same cycle. The received word comes back as a one-cycle `rx_valid` pulse with `rx_data`. That side has no back-pressure: the consumer must take the word in the pulse cycle, although `rx_data` keeps its value until the next transfer ends.

Top module: `conv_link_master`

## Requirements
- R1: The serial clock period is N system cycles, where N is `div_cfg` limited to the range 2..17 (0 and 1 give 2; 18..31 give 17).
- R2: In each bit the serial clock is high for ceil(N/2) cycles and then low for floor(N/2) cycles, so odd N gives one extra high cycle.
- R3: `sdo` carries the accepted word MSB first. It changes only in the cycle where `sclk` rises, which keeps it stable across each falling edge where the device samples it.
- R4: `sdi` is sampled at every rising serial edge, the first one included, and shifted in MSB first. The 26 samples form `rx_data`.
- R5: `sel_n` goes low with the first rising serial edge and stays low until the low phase of bit 26 ends. A transfer keeps `busy` high for exactly 26·N cycles.
- R6: While idle, `sclk` is low, `sel_n` is high, and `sdo` holds the last bit it sent.
- R7: `tx_ready` is the inverse of `busy`. A word is accepted when `tx_valid` is high and `tx_ready` is high. A `tx_valid` that arrives while busy starts nothing and does not change the word being sent.
- R8: `rx_valid` is high for exactly one cycle, the first cycle after `busy` falls. `rx_data` holds that value until the next completion.
- R9: A synchronous active-high `rst` gives `busy`=0, `sclk`=0, `sel_n`=1, `rx_valid`=0 and `tx_ready`=1.
- R10: Changes on `div_cfg` during a transfer do not change that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_cfg | input | 5 | Requested divide ratio |
| tx_valid | input | 1 | Word to send is offered |
| tx_ready | output | 1 | Block can accept a word |
| tx_data | input | 26 | Word to send |
| rx_valid | output | 1 | One-cycle pulse: received word ready |
| rx_data | output | 26 | Received word |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| sel_n | output | 1 | Transfer select, active low |
| sdo | output | 1 | Serial data to the device |
| sdi | input | 1 | Serial data from the device |

## Verification
The bench builds the block with its default parameters: a 26-bit word, ratio limits 2 and 17, and a 5-bit divider field. Because that field is narrow, the bench sweeps all 32 settings. The sweep covers every legal ratio, both clamped regions and every odd/even duty case, and each setting gets its own pair of words. A bench model of the device shifts data on falling serial edges, which checks the edge relationship in both directions. Every transfer also carries a start request during the transfer and a divider change after it has begun.

// File: rtl/conv_link_pkg.sv
package conv_link_pkg;

  typedef enum logic {
    LINK_IDLE = 1'b0,
    LINK_XFER = 1'b1
  } link_state_e;

  // Limit a requested ratio to [lo, hi].
  function automatic int unsigned clamp_ratio(input int unsigned req,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/cl_sclk_gen.sv
module cl_sclk_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             last_bit,
  input  logic [CNT_W-1:0] ratio,
  output logic             sclk,
  output logic             bit_end
);

  logic [CNT_W-1:0] ratio_q;
  logic [CNT_W-1:0] high_q;
  logic [CNT_W-1:0] cnt;

  assign bit_end = run && (cnt == ratio_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= CNT_W'(2);
      high_q  <= CNT_W'(1);
      cnt     <= '0;
      sclk    <= 1'b0;
    end else if (start) begin
      ratio_q <= ratio;
      high_q  <= CNT_W'((ratio + 1'b1) >> 1);
      cnt     <= '0;
      sclk    <= 1'b1;
    end else if (run) begin
      if (cnt == ratio_q - 1'b1) begin
        cnt  <= '0;
        sclk <= !last_bit;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == high_q - 1'b1) sclk <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cl_shifter.sv
module cl_shifter #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] tx_word,
  input  logic         advance,
  input  logic         sdi,
  output logic         sdo,
  output logic [W-1:0] rx_word
);

  logic [W-1:0] tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      sdo     <= 1'b0;
      rx_word <= '0;
    end else if (load) begin
      sdo     <= tx_word[W-1];
      tx_sh   <= tx_word << 1;
      rx_word <= {rx_word[W-2:0], sdi};
    end else if (advance) begin
      sdo     <= tx_sh[W-1];
      tx_sh   <= tx_sh << 1;
      rx_word <= {rx_word[W-2:0], sdi};
    end
  end

endmodule

// File: rtl/conv_link_master.sv
module conv_link_master
  import conv_link_pkg::*;
#(
  parameter int WORD_W  = 26,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 17,
  parameter int CFG_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  div_cfg,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              sel_n,
  output logic              sdo,
  input  logic              sdi
);

  localparam int CNT_W = $clog2(DIV_MAX + 2);
  localparam int BIT_W = $clog2(WORD_W);

  link_state_e       state;
  logic [BIT_W-1:0]  bit_idx;
  logic              accept;
  logic              last_bit;
  logic              bit_end;
  logic              advance;
  logic [CNT_W-1:0]  ratio_c;
  logic [WORD_W-1:0] rx_word;

  assign busy     = (state == LINK_XFER);
  assign tx_ready = !busy;
  assign accept   = tx_valid && tx_ready;
  assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));
  assign advance  = bit_end && !last_bit;
  assign ratio_c  = CNT_W'(clamp_ratio(int'(unsigned'(div_cfg)), DIV_MIN, DIV_MAX));

  cl_sclk_gen #(.CNT_W(CNT_W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .run      (busy),
    .last_bit (last_bit),
    .ratio    (ratio_c),
    .sclk     (sclk),
    .bit_end  (bit_end)
  );

  cl_shifter #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .tx_word (tx_data),
    .advance (advance),
    .sdi     (sdi),
    .sdo     (sdo),
    .rx_word (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LINK_IDLE;
      bit_idx  <= '0;
      sel_n    <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (accept) begin
        state   <= LINK_XFER;
        bit_idx <= '0;
        sel_n   <= 1'b0;
      end else if (bit_end) begin
        if (last_bit) begin
          state    <= LINK_IDLE;
          sel_n    <= 1'b1;
          rx_valid <= 1'b1;
          rx_data  <= rx_word;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/conv_link_master_chk.sv
module conv_link_master_chk #(
  parameter int WORD_W = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_data,
  input logic              busy,
  input logic              sclk,
  input logic              sel_n,
  input logic              sdo
);

  // R6: idle line levels
  p_idle_lines_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sel_n && !sclk));

  // R7: no acceptance while busy
  p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_ready);

  // R7: an accepted word starts a transfer
  p_accept_starts_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (busy && !sel_n && sclk));

  // R8: single-cycle completion pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8: completion follows the end of busy
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rx_valid);

  // R8: result word holds between completions
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data));

  // R3: data moves only with a rising serial edge
  p_sdo_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    !$rose(sclk) |-> $stable(sdo));

  // R5: select is asserted whenever the serial clock is high
  p_sel_cover_r5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !sel_n);

endmodule

bind conv_link_master conv_link_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_data  (rx_data),
  .busy     (busy),
  .sclk     (sclk),
  .sel_n    (sel_n),
  .sdo      (sdo)
);

// File: tb/test_conv_link_master.sv
module test_conv_link_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  div_cfg = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [25:0] tx_data = '0;
  logic        rx_valid;
  logic [25:0] rx_data;
  logic        busy;
  logic        sclk;
  logic        sel_n;
  logic        sdo;
  logic        sdi;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  // external device model: shifts on falling serial edges
  logic [25:0] dev_word = '0;
  logic [25:0] dev_rx   = '0;
  int          dev_k    = 0;

  always #5 clk = ~clk;

  conv_link_master i_conv_link_master (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .sclk(sclk), .sel_n(sel_n),
    .sdo(sdo), .sdi(sdi)
  );

  assign sdi = (dev_k < 26) ? dev_word[5'(25 - dev_k)] : 1'b0;

  always @(negedge sclk or posedge sel_n) begin
    if (sel_n) dev_k <= 0;
    else begin
      dev_k  <= dev_k + 1;
      dev_rx <= {dev_rx[24:0], sdo};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic xfer(input int cfg);
    int n, h, c, wave_bad, sel_bad, rdy_bad;
    logic [25:0] tw, dw;
    n  = (cfg < 2) ? 2 : ((cfg > 17) ? 17 : cfg);
    h  = (n + 1) / 2;
    tw = 26'(cfg * 32'h2d4a3 ^ 32'h2aa5a5);
    dw = 26'(~(cfg * 32'h1b3c7) ^ 32'h15a5a5);
    dev_word = dw;
    tx_data  = tw;
    div_cfg  = 5'(cfg);
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy === 1'b1 && sel_n === 1'b0 && sclk === 1'b1, "R7 accept/R5 select low",
        {busy, sel_n, sclk}, 3'b101);
    c = 0; wave_bad = 0; sel_bad = 0; rdy_bad = 0;
    while (busy === 1'b1 && c < 1000) begin
      if (sclk !== ((c % n) < h)) wave_bad++;
      if (sel_n !== 1'b0) sel_bad++;
      if (tx_ready !== 1'b0) rdy_bad++;
      if (c == 3) begin   // R7 / R10: request and ratio change mid-transfer
        tx_valid = 1'b1;
        tx_data  = ~tw;
        div_cfg  = 5'(cfg + 7);
      end
      if (c == 4) tx_valid = 1'b0;
      @(negedge clk);
      c++;
    end
    chk(c == 26 * n, "R1/R10 transfer length", c, 26 * n);
    chk(wave_bad == 0, "R2 serial clock duty", wave_bad, 0);
    chk(sel_bad == 0, "R5 select held", sel_bad, 0);
    chk(rdy_bad == 0, "R7 ready low while busy", rdy_bad, 0);
    chk(rx_valid === 1'b1, "R8 done pulse", rx_valid, 1);
    chk(rx_data === dw, "R4 received word", rx_data, dw);
    chk(dev_rx === tw, "R3 sent word", dev_rx, tw);
    chk(sel_n === 1'b1 && sclk === 1'b0, "R6 idle lines", {sel_n, sclk}, 2'b10);
    @(negedge clk);
    chk(rx_valid === 1'b0, "R8 pulse width", rx_valid, 0);
    chk(busy === 1'b0, "R7 busy request ignored", busy, 0);
    chk(sdo === tw[0] && rx_data === dw, "R6 sdo hold / R8 rx hold",
        {sdo, rx_data}, {tw[0], dw});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0 && sclk === 1'b0, "R9 reset busy/sclk", {busy, sclk}, 0);
    chk(sel_n === 1'b1, "R9 reset select", sel_n, 1);
    chk(rx_valid === 1'b0, "R9 reset rx_valid", rx_valid, 0);
    chk(tx_ready === 1'b1, "R9 reset ready", tx_ready, 1);
    for (int cfg = 0; cfg < 32; cfg++) begin
      xfer(cfg);
      @(negedge clk);
    end
    finish_run();
  end

endmodule